// File: doc/BRIEF.md
# Superscalar Decode Stage with Skid Buffer

This block is the decode step of a superscalar pipeline. Every cycle it can take in a bundle of up to `DECODE_WIDTH` instruction records from fetch. It passes the live records on to rename in a registered output bundle, packed from slot 0 in program order. Records that are invalid or already marked squashed are dropped. Each forwarded record has a ready-to-issue flag, set when the instruction reads no source registers, and a resolved next PC.

The stage has three downstream stall inputs (rename, execute, commit) and two flush inputs from commit (a squash and a reorder-buffer squash). While stalled, it stores whole fetch bundles in a skid buffer. When the stall clears, it drains the buffer oldest bundle first and keeps its stall-to-fetch level raised until the buffer is empty. It also resolves direct unconditional branches. When such a branch's target does not match its prediction, the stage forwards the branch and drops the younger records in that bundle. It then sends fetch a one-cycle redirect carrying the target and the branch's sequence number, and enters its squashing state.

Top module: `decodeStage`

## Requirements
- R1: While reset is held, `renameCount` is 0 and `stallToFetch`, `redirValid` and `skidOverflow` are all low.
- R2: In normal running, one cycle after a fetch bundle arrives, `renameCount` equals the number of records in it that are valid (bit `valid`) and not squashed (bit `squashed`). Those records appear in slots 0 upward in their original slot order, with no gaps.
- R3: Each output record has `canIssue` set exactly when its `numSrc` field is 0. Its `nextPc` is set as follows: for a direct unconditional branch, the branch target; otherwise the predicted target if `predTaken` is set, else `pc + 4`.
- R4: A stall on any of the three stall inputs, with no commit flush, suppresses output and stores the valid fetch bundle. From the next cycle `stallToFetch` is high, and it stays high while any stall persists.
- R5: When all stalls clear while blocked, the next cycle gives no output and keeps `stallToFetch` high. The stored bundles then leave one per cycle, oldest first. Fetch bundles that arrive during the drain are queued behind them. `stallToFetch` falls in the cycle after the last stored bundle is sent.
- R6: `commitSquash` or `commitRobSquash` in any state takes priority over a stall. The stage then gives no output, empties the skid buffer and lowers `stallToFetch`. It returns to normal running only one cycle after both inputs are low, and that cycle also gives no output.
- R7: A direct unconditional branch whose `predTaken` is clear, or whose `predTarget` differs from `target`, is forwarded, and all younger records in its bundle are dropped. The next cycle carries a one-cycle `redirValid` pulse with `redirPc` equal to the target and `redirSeq` equal to the branch's sequence number. The cycle after that gives no output.
- R8: A push into a full skid buffer with no pop in the same cycle sets `skidOverflow`. The flag stays set until reset, flushes included.
- R9: A direct unconditional branch that was predicted taken to the correct target raises no redirect, and the younger records in its bundle are forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchBundle | input | DECODE_WIDTH*118 | Fetch records, slot i in bits [i*118 +: 118] |
| stallRename | input | 1 | Stall from rename |
| stallExec | input | 1 | Stall from execute |
| stallCommit | input | 1 | Stall from commit |
| commitSquash | input | 1 | Squash from commit |
| commitRobSquash | input | 1 | Reorder-buffer squash in progress |
| renameCount | output | clog2(DECODE_WIDTH+1) | Number of valid output records |
| renameBundle | output | DECODE_WIDTH*81 | Output records {seqNum, pc, nextPc, canIssue} |
| stallToFetch | output | 1 | Back-pressure level to fetch |
| redirValid | output | 1 | One-cycle mispredict redirect |
| redirPc | output | 32 | Corrected next PC |
| redirSeq | output | 16 | Sequence number of the mispredicted branch |
| skidOverflow | output | 1 | Sticky skid buffer overflow |

## Verification
The collision of interest is a commit flush that arrives in the same cycle as a downstream stall. A second case is a flush that lands while the skid buffer still holds bundles. The bench raises all three stalls together with `commitSquash` and expects no output and a low `stallToFetch`. It then stalls one bundle into the buffer, flushes, and checks that the next delivered bundle is the fresh one rather than the stored one. It also checks that the mispredict redirect goes out in the same cycle that the branch itself is forwarded.

// File: rtl/decodePkg.sv
package decodePkg;

  typedef struct packed {
    logic        valid;
    logic        squashed;
    logic [15:0] seqNum;
    logic [31:0] pc;
    logic        predTaken;
    logic [31:0] predTarget;
    logic        isDirUncond;
    logic [31:0] target;
    logic [1:0]  numSrc;
  } fetchRecT;

  typedef struct packed {
    logic [15:0] seqNum;
    logic [31:0] pc;
    logic [31:0] nextPc;
    logic        canIssue;
  } renRecT;

  localparam int FETCH_REC_W = $bits(fetchRecT);
  localparam int REN_REC_W   = $bits(renRecT);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RUN, ST_BLOCKED, ST_UNBLOCK, ST_SQUASH
  } decStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
    logic process;
    logic useSkid;
  } ctrlStrobeT;

endpackage

// File: rtl/decodeCtrl.sv
module decodeCtrl
  import decodePkg::*;
#(
  parameter int SKID_DEPTH = 4,
  localparam int SKID_CNT_W = $clog2(SKID_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  anyStall,
  input  logic                  anySquash,
  input  logic                  fetchHasInst,
  input  logic [SKID_CNT_W-1:0] skidCount,
  input  logic                  mispredict,
  output ctrlStrobeT            strb,
  output logic                  stallToFetch,
  output decStateT              state
);

  decStateT nextState;

  always_comb begin
    int remaining;
    nextState    = state;
    strb         = '0;
    strb.useSkid = (state == ST_UNBLOCK);
    remaining    = 0;
    case (state)
      ST_IDLE, ST_RUN: begin
        if (anySquash) begin
          nextState  = ST_SQUASH;
          strb.flush = 1'b1;
        end else if (anyStall) begin
          nextState = ST_BLOCKED;
          strb.push = fetchHasInst;
        end else if (fetchHasInst) begin
          strb.process = 1'b1;
          strb.flush   = mispredict;
          nextState    = mispredict ? ST_SQUASH : ST_RUN;
        end
      end
      ST_BLOCKED: begin
        if (anySquash) begin
          nextState  = ST_SQUASH;
          strb.flush = 1'b1;
        end else begin
          strb.push = fetchHasInst;
          if (!anyStall) nextState = ST_UNBLOCK;
        end
      end
      ST_UNBLOCK: begin
        if (anySquash) begin
          nextState  = ST_SQUASH;
          strb.flush = 1'b1;
        end else if (anyStall) begin
          nextState = ST_BLOCKED;
          strb.push = fetchHasInst;
        end else begin
          strb.process = (skidCount != '0);
          strb.pop     = (skidCount != '0);
          if (strb.process && mispredict) begin
            strb.flush = 1'b1;
            nextState  = ST_SQUASH;
          end else begin
            strb.push = fetchHasInst;
            remaining = int'(skidCount) - int'(strb.pop) + int'(strb.push);
            nextState = (remaining != 0) ? ST_UNBLOCK : ST_RUN;
          end
        end
      end
      ST_SQUASH: begin
        if (!anySquash) nextState = ST_RUN;
        else            strb.flush = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      stallToFetch <= 1'b0;
    end else begin
      state        <= nextState;
      stallToFetch <= (nextState == ST_BLOCKED) || (nextState == ST_UNBLOCK);
    end
  end

endmodule

// File: rtl/decodeDatapath.sv
module decodeDatapath
  import decodePkg::*;
#(
  parameter int DECODE_WIDTH = 2,
  parameter int SKID_DEPTH   = 4,
  localparam int FW         = FETCH_REC_W,
  localparam int RW         = REN_REC_W,
  localparam int OUT_CNT_W  = $clog2(DECODE_WIDTH + 1),
  localparam int SKID_CNT_W = $clog2(SKID_DEPTH + 1),
  localparam int PTR_W      = (SKID_DEPTH > 1) ? $clog2(SKID_DEPTH) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [DECODE_WIDTH*FW-1:0] fetchBundle,
  input  ctrlStrobeT                 strb,
  output logic                       fetchHasInst,
  output logic [SKID_CNT_W-1:0]      skidCount,
  output logic                       mispredict,
  output logic [OUT_CNT_W-1:0]       renameCount,
  output logic [DECODE_WIDTH*RW-1:0] renameBundle,
  output logic                       redirValid,
  output logic [31:0]                redirPc,
  output logic [15:0]                redirSeq,
  output logic                       skidOverflow
);

  logic [DECODE_WIDTH*FW-1:0] skidMem [SKID_DEPTH];
  logic [PTR_W-1:0]           rdPtr, wrPtr;
  logic                       pushOk;
  logic [DECODE_WIDTH*FW-1:0] srcFlat;
  fetchRecT                   fetchRec [DECODE_WIDTH];
  fetchRecT                   srcRec   [DECODE_WIDTH];
  renRecT                     outRec   [DECODE_WIDTH];
  renRecT                     outQ     [DECODE_WIDTH];
  logic [OUT_CNT_W-1:0]       outCnt;
  logic [31:0]                brPc;
  logic [15:0]                brSeq;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(SKID_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign srcFlat = strb.useSkid ? skidMem[rdPtr] : fetchBundle;
  assign pushOk  = strb.push && ((int'(skidCount) < SKID_DEPTH) || strb.pop);

  for (genvar i = 0; i < DECODE_WIDTH; i++) begin : g_slot
    assign fetchRec[i] = fetchBundle[i*FW +: FW];
    assign srcRec[i]   = srcFlat[i*FW +: FW];
    assign renameBundle[i*RW +: RW] = outQ[i];
  end

  always_comb begin
    fetchHasInst = 1'b0;
    for (int i = 0; i < DECODE_WIDTH; i++) fetchHasInst |= fetchRec[i].valid;
  end

  // pack live records from slot 0; stop after a mispredicted branch
  always_comb begin
    renRecT o;
    logic   bad;
    logic   stop;
    stop       = 1'b0;
    mispredict = 1'b0;
    outCnt     = '0;
    brPc       = '0;
    brSeq      = '0;
    o          = '0;
    bad        = 1'b0;
    for (int j = 0; j < DECODE_WIDTH; j++) outRec[j] = '0;
    for (int i = 0; i < DECODE_WIDTH; i++) begin
      if (srcRec[i].valid && !srcRec[i].squashed && !stop) begin
        o.seqNum   = srcRec[i].seqNum;
        o.pc       = srcRec[i].pc;
        o.canIssue = (srcRec[i].numSrc == 2'd0);
        if (srcRec[i].isDirUncond)    o.nextPc = srcRec[i].target;
        else if (srcRec[i].predTaken) o.nextPc = srcRec[i].predTarget;
        else                          o.nextPc = srcRec[i].pc + 32'd4;
        bad = srcRec[i].isDirUncond &&
              (!srcRec[i].predTaken || (srcRec[i].predTarget != srcRec[i].target));
        for (int j = 0; j < DECODE_WIDTH; j++)
          if (OUT_CNT_W'(j) == outCnt) outRec[j] = o;
        outCnt = outCnt + 1'b1;
        if (bad) begin
          stop       = 1'b1;
          mispredict = 1'b1;
          brPc       = srcRec[i].target;
          brSeq      = srcRec[i].seqNum;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk && !strb.flush) skidMem[wrPtr] <= fetchBundle;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr        <= '0;
      wrPtr        <= '0;
      skidCount    <= '0;
      skidOverflow <= 1'b0;
    end else begin
      if (strb.push && !pushOk && !strb.flush) skidOverflow <= 1'b1;
      if (strb.flush) begin
        rdPtr     <= '0;
        wrPtr     <= '0;
        skidCount <= '0;
      end else begin
        if (pushOk)   wrPtr <= nextPtr(wrPtr);
        if (strb.pop) rdPtr <= nextPtr(rdPtr);
        skidCount <= skidCount + SKID_CNT_W'(pushOk) - SKID_CNT_W'(strb.pop);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      renameCount <= '0;
      redirValid  <= 1'b0;
      redirPc     <= '0;
      redirSeq    <= '0;
      for (int j = 0; j < DECODE_WIDTH; j++) outQ[j] <= '0;
    end else begin
      renameCount <= strb.process ? outCnt : '0;
      redirValid  <= strb.process && mispredict;
      if (strb.process && mispredict) begin
        redirPc  <= brPc;
        redirSeq <= brSeq;
      end
      for (int j = 0; j < DECODE_WIDTH; j++)
        outQ[j] <= strb.process ? outRec[j] : '0;
    end
  end

endmodule

// File: rtl/decodeStage.sv
module decodeStage
  import decodePkg::*;
#(
  parameter int DECODE_WIDTH = 2,
  parameter int SKID_DEPTH   = 4,
  localparam int OUT_CNT_W   = $clog2(DECODE_WIDTH + 1),
  localparam int SKID_CNT_W  = $clog2(SKID_DEPTH + 1)
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [DECODE_WIDTH*FETCH_REC_W-1:0] fetchBundle,
  input  logic                                stallRename,
  input  logic                                stallExec,
  input  logic                                stallCommit,
  input  logic                                commitSquash,
  input  logic                                commitRobSquash,
  output logic [OUT_CNT_W-1:0]                renameCount,
  output logic [DECODE_WIDTH*REN_REC_W-1:0]   renameBundle,
  output logic                                stallToFetch,
  output logic                                redirValid,
  output logic [31:0]                         redirPc,
  output logic [15:0]                         redirSeq,
  output logic                                skidOverflow
);

  ctrlStrobeT            strb;
  decStateT              ctrlState;
  logic                  fetchHasInst;
  logic                  mispredict;
  logic [SKID_CNT_W-1:0] skidCount;

  decodeCtrl #(.SKID_DEPTH(SKID_DEPTH)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .anyStall     (stallRename | stallExec | stallCommit),
    .anySquash    (commitSquash | commitRobSquash),
    .fetchHasInst (fetchHasInst),
    .skidCount    (skidCount),
    .mispredict   (mispredict),
    .strb         (strb),
    .stallToFetch (stallToFetch),
    .state        (ctrlState)
  );

  decodeDatapath #(.DECODE_WIDTH(DECODE_WIDTH), .SKID_DEPTH(SKID_DEPTH)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .fetchBundle  (fetchBundle),
    .strb         (strb),
    .fetchHasInst (fetchHasInst),
    .skidCount    (skidCount),
    .mispredict   (mispredict),
    .renameCount  (renameCount),
    .renameBundle (renameBundle),
    .redirValid   (redirValid),
    .redirPc      (redirPc),
    .redirSeq     (redirSeq),
    .skidOverflow (skidOverflow)
  );

endmodule

// File: rtl/decodeStageChk.sv
module decodeStageChk
  import decodePkg::*;
#(
  parameter int DECODE_WIDTH = 2,
  localparam int OUT_CNT_W   = $clog2(DECODE_WIDTH + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 stallRename,
  input logic                 stallExec,
  input logic                 stallCommit,
  input logic                 commitSquash,
  input logic                 commitRobSquash,
  input logic [OUT_CNT_W-1:0] renameCount,
  input logic                 stallToFetch,
  input logic                 redirValid,
  input logic                 skidOverflow,
  input decStateT             ctrlState
);

  logic anyStall, anySquash;
  assign anyStall  = stallRename | stallExec | stallCommit;
  assign anySquash = commitSquash | commitRobSquash;

  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rstN)
    int'(renameCount) <= DECODE_WIDTH); // R2

  AST_STALL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    anyStall && !anySquash && ctrlState != ST_SQUASH |=> stallToFetch); // R4

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    anySquash |=> renameCount == '0 && !stallToFetch); // R6

  AST_REDIR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |=> !redirValid && renameCount == '0); // R7

  AST_REDIR_WITH_BRANCH: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |-> renameCount != '0); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    skidOverflow |=> skidOverflow); // R8

endmodule

bind decodeStage decodeStageChk #(.DECODE_WIDTH(DECODE_WIDTH)) chk_i (
  .clk             (clk),
  .rstN            (rstN),
  .stallRename     (stallRename),
  .stallExec       (stallExec),
  .stallCommit     (stallCommit),
  .commitSquash    (commitSquash),
  .commitRobSquash (commitRobSquash),
  .renameCount     (renameCount),
  .stallToFetch    (stallToFetch),
  .redirValid      (redirValid),
  .skidOverflow    (skidOverflow),
  .ctrlState       (ctrlState)
);

// File: tb/decodeStage_tb_top.sv
module decodeStage_tb_top;
  import decodePkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 2;
  localparam int SD = 4;

  logic                      clk = 1'b0;
  logic                      rstN;
  logic [DW*FETCH_REC_W-1:0] fetchBundle;
  logic                      stallRename, stallExec, stallCommit;
  logic                      commitSquash, commitRobSquash;
  logic [1:0]                renameCount;
  logic [DW*REN_REC_W-1:0]   renameBundle;
  logic                      stallToFetch, redirValid, skidOverflow;
  logic [31:0]               redirPc;
  logic [15:0]               redirSeq;

  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  decodeStage #(.DECODE_WIDTH(DW), .SKID_DEPTH(SD)) dut_i (
    .clk(clk), .rstN(rstN), .fetchBundle(fetchBundle),
    .stallRename(stallRename), .stallExec(stallExec), .stallCommit(stallCommit),
    .commitSquash(commitSquash), .commitRobSquash(commitRobSquash),
    .renameCount(renameCount), .renameBundle(renameBundle),
    .stallToFetch(stallToFetch), .redirValid(redirValid),
    .redirPc(redirPc), .redirSeq(redirSeq), .skidOverflow(skidOverflow)
  );

  // kind: 0 plain, 1 slot0 mispredicted direct branch, 2 slot0 correct direct branch
  typedef struct packed {
    logic [2:0] stl;   // {rename, exec, commit}
    logic       sq;
    logic       rob;
    logic [1:0] fv;
    logic [1:0] fsq;
    logic [7:0] base;
    logic [1:0] kind;
    logic [3:0] req;
    logic [1:0] eCnt;
    logic [7:0] eSeq;
    logic       eStall;
    logic       eRedir;
  } vecT;

  localparam vecT VECS [20] = '{
    '{3'b000,1'b0,1'b0,2'b11,2'b00,8'd10, 2'd0,4'd2,2'd2,8'd10, 1'b0,1'b0}, // R2 full bundle
    '{3'b000,1'b0,1'b0,2'b10,2'b00,8'd20, 2'd0,4'd2,2'd1,8'd21, 1'b0,1'b0}, // R2 packed from slot 0
    '{3'b000,1'b0,1'b0,2'b11,2'b01,8'd30, 2'd0,4'd2,2'd1,8'd31, 1'b0,1'b0}, // R2 squashed dropped
    '{3'b100,1'b0,1'b0,2'b11,2'b00,8'd40, 2'd0,4'd4,2'd0,8'd0,  1'b1,1'b0}, // R4 block, store 40
    '{3'b100,1'b0,1'b0,2'b11,2'b00,8'd50, 2'd0,4'd4,2'd0,8'd0,  1'b1,1'b0}, // R4 store 50
    '{3'b000,1'b0,1'b0,2'b00,2'b00,8'd0,  2'd0,4'd5,2'd0,8'd0,  1'b1,1'b0}, // R5 enter drain
    '{3'b000,1'b0,1'b0,2'b11,2'b00,8'd60, 2'd0,4'd5,2'd2,8'd40, 1'b1,1'b0}, // R5 head 40, queue 60
    '{3'b000,1'b0,1'b0,2'b00,2'b00,8'd0,  2'd0,4'd5,2'd2,8'd50, 1'b1,1'b0}, // R5
    '{3'b000,1'b0,1'b0,2'b00,2'b00,8'd0,  2'd0,4'd5,2'd2,8'd60, 1'b0,1'b0}, // R5 last, stall drops
    '{3'b000,1'b0,1'b0,2'b11,2'b00,8'd70, 2'd1,4'd7,2'd1,8'd70, 1'b0,1'b1}, // R7 mispredict
    '{3'b000,1'b0,1'b0,2'b11,2'b00,8'd80, 2'd0,4'd7,2'd0,8'd0,  1'b0,1'b0}, // R7 quiet cycle
    '{3'b000,1'b0,1'b0,2'b11,2'b00,8'd90, 2'd0,4'd2,2'd2,8'd90, 1'b0,1'b0}, // R2
    '{3'b111,1'b1,1'b0,2'b11,2'b00,8'd100,2'd0,4'd6,2'd0,8'd0,  1'b0,1'b0}, // R6 squash beats stall
    '{3'b000,1'b0,1'b1,2'b11,2'b00,8'd110,2'd0,4'd6,2'd0,8'd0,  1'b0,1'b0}, // R6 rob squash holds
    '{3'b000,1'b0,1'b0,2'b11,2'b00,8'd112,2'd0,4'd6,2'd0,8'd0,  1'b0,1'b0}, // R6 leaving cycle
    '{3'b000,1'b0,1'b0,2'b11,2'b00,8'd120,2'd0,4'd6,2'd2,8'd120,1'b0,1'b0}, // R6 back to running
    '{3'b010,1'b0,1'b0,2'b11,2'b00,8'd130,2'd0,4'd4,2'd0,8'd0,  1'b1,1'b0}, // R4 store 130
    '{3'b010,1'b1,1'b0,2'b00,2'b00,8'd0,  2'd0,4'd6,2'd0,8'd0,  1'b0,1'b0}, // R6 flush stored
    '{3'b000,1'b0,1'b0,2'b00,2'b00,8'd0,  2'd0,4'd6,2'd0,8'd0,  1'b0,1'b0}, // R6
    '{3'b000,1'b0,1'b0,2'b11,2'b00,8'd140,2'd0,4'd6,2'd2,8'd140,1'b0,1'b0}  // R6 130 gone
  };

  function automatic logic [DW*FETCH_REC_W-1:0] mkBundle(
      input logic [1:0] v, input logic [1:0] sq, input int base, input int kind);
    logic [DW*FETCH_REC_W-1:0] flat;
    fetchRecT r;
    flat = '0;
    for (int i = 0; i < DW; i++) begin
      r             = '0;
      r.valid       = v[i];
      r.squashed    = sq[i];
      r.seqNum      = 16'(base + i);
      r.pc          = 32'((base + i) * 4);
      r.target      = 32'h1000 + 32'(base + i);
      r.numSrc      = 2'(i);
      if (i == 0 && kind != 0) r.isDirUncond = 1'b1;
      if (i == 0 && kind == 2) begin
        r.predTaken  = 1'b1;
        r.predTarget = r.target;
      end
      flat[i*FETCH_REC_W +: FETCH_REC_W] = r;
    end
    return flat;
  endfunction

  function automatic renRecT outSlot(input int i);
    return renameBundle[i*REN_REC_W +: REN_REC_W];
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] stl, input logic sq, input logic rob,
                       input logic [DW*FETCH_REC_W-1:0] fb);
    {stallRename, stallExec, stallCommit} = stl;
    commitSquash    = sq;
    commitRobSquash = rob;
    fetchBundle     = fb;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    drive(3'b000, 1'b0, 1'b0, '0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "count", renameCount, 0);
    chk("R1", "stall", stallToFetch, 0);
    chk("R1", "redir", redirValid, 0);
    chk("R1", "ovf", skidOverflow, 0);
    rstN = 1'b1;

    for (int k = 0; k < 20; k++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", VECS[k].req, k);
      drive(VECS[k].stl, VECS[k].sq, VECS[k].rob,
            mkBundle(VECS[k].fv, VECS[k].fsq, int'(VECS[k].base), int'(VECS[k].kind)));
      @(negedge clk);
      chk(tag, "count", renameCount, VECS[k].eCnt);
      if (VECS[k].eCnt != 0) chk(tag, "seq0", outSlot(0).seqNum, VECS[k].eSeq);
      chk(tag, "stall", stallToFetch, VECS[k].eStall);
      chk(tag, "redir", redirValid, VECS[k].eRedir);
    end

    // R7 / R3: redirect contents and branch record
    drive(3'b000, 1'b0, 1'b0, mkBundle(2'b11, 2'b00, 200, 1));
    @(negedge clk);
    chk("R7", "redirValid", redirValid, 1);
    chk("R7", "redirPc", redirPc, 32'h1000 + 200);
    chk("R7", "redirSeq", redirSeq, 200);
    chk("R7", "count", renameCount, 1);
    chk("R3", "branch nextPc", outSlot(0).nextPc, 32'h1000 + 200);
    chk("R3", "slot0 canIssue", outSlot(0).canIssue, 1);
    drive(3'b000, 1'b0, 1'b0, '0);
    @(negedge clk);
    chk("R7", "pulse ends", redirValid, 0);

    // R9 / R3: correctly predicted direct branch
    drive(3'b000, 1'b0, 1'b0, mkBundle(2'b11, 2'b00, 210, 2));
    @(negedge clk);
    chk("R9", "no redirect", redirValid, 0);
    chk("R9", "count", renameCount, 2);
    chk("R9", "slot1 seq", outSlot(1).seqNum, 211);
    chk("R3", "slot1 nextPc", outSlot(1).nextPc, 211 * 4 + 4);
    chk("R3", "slot1 canIssue", outSlot(1).canIssue, 0);

    // R8: overflow on fifth stored bundle, sticky through flush
    for (int i = 0; i < SD + 1; i++) begin
      drive(3'b001, 1'b0, 1'b0, mkBundle(2'b11, 2'b00, 220 + 2 * i, 0));
      @(negedge clk);
      chk("R8", $sformatf("ovf after push %0d", i + 1), skidOverflow, (i == SD) ? 1 : 0);
    end
    drive(3'b000, 1'b1, 1'b0, '0);
    @(negedge clk);
    chk("R8", "ovf after flush", skidOverflow, 1);
    chk("R6", "stall after flush", stallToFetch, 0);
    drive(3'b000, 1'b0, 1'b0, '0);
    @(negedge clk);
    drive(3'b000, 1'b0, 1'b0, mkBundle(2'b01, 2'b00, 240, 0));
    @(negedge clk);
    chk("R2", "count after overflow", renameCount, 1);
    chk("R2", "seq after overflow", outSlot(0).seqNum, 240);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule